// File: doc/BRIEF.md
# Time-Sliced Panel Dispatcher with Cross-Panel Recirculation

This block feeds a switch built from several identical multistage fabric panels. It keeps a slot counter that wraps at the panel count. In each clock, every arriving cell goes to the one panel that the current slot names. All other panels see no traffic in that clock.

The block also moves cells that reached the output of a panel's final stage without being delivered. Such a cell is passed to the next panel in cyclic order, on the same port lane. It may only enter the last full fabric copy of that panel, which is the final n = log_b N stages. The lowest candidate stage whose switching element reports a free slot is chosen, and the cell enters there through that stage's input multiplexer. When every candidate point is busy, the cell is dropped.

Two counters track these events. A saturating counter holds the number of dropped cells. One saturating counter per panel holds the number of cells injected into that panel. The stages inside each panel are outside the block; it sees them only as occupancy flags.

Top module: `pnl_dispatch`

## Requirements
- R1: While `rst_n` is low, `panel_sel` is 0 and both `drop_cnt` and every `inj_cnt` field are 0.
- R2: After reset is released, `panel_sel` advances by one at each rising clock edge and wraps from Y-1 back to 0.
- R3: Lane q of panel p sits at bit p*N+q of `pnl_vld` and at bits (p*N+q)*W of `pnl_data`. That lane carries `cell_vld[q]` and cell q's data when p equals `panel_sel`. Every lane of every other panel shows valid 0 and data 0.
- R4: A recirculation request from lane q of panel i is served on lane q of panel (i+1) mod Y. The injected data equals the request data, and `inj_data` is 0 on any lane that is not injecting.
- R5: The busy flag for candidate k (k = 0 is stage X-n+1) of destination lane l = p*N+q is `slot_busy[l*n+k]`, where 1 means busy. An injection reports in `inj_stage[l*SW +: SW]` the 1-based stage number X-n+1+k, using the lowest k that is free.
- R6: No cell is ever injected at a candidate point whose busy flag is 1.
- R7: A request whose candidates are all busy gives no injection on its lane. A lane with no request never injects, whatever its flags show.
- R8: `drop_cnt` adds, at each clock edge, the number of requests dropped in that cycle. It saturates at its all-ones value.
- R9: `inj_cnt[p*RW +: RW]` adds, at each clock edge, the number of cells injected into panel p in that cycle. It saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_vld | input | N | Arriving cell valid per port |
| cell_data | input | N*W | Arriving cell payloads |
| panel_sel | output | PW | Panel receiving this cycle's cells |
| pnl_vld | output | Y*N | Dispatched valid per panel lane |
| pnl_data | output | Y*N*W | Dispatched payload per panel lane |
| rc_vld | input | Y*N | Recirculation request per source panel lane |
| rc_data | input | Y*N*W | Recirculated payload per source panel lane |
| slot_busy | input | Y*N*n | Candidate busy flags per destination lane |
| inj_vld | output | Y*N | Injection taking place per destination lane |
| inj_stage | output | Y*N*SW | Chosen stage number per destination lane |
| inj_data | output | Y*N*W | Injected payload per destination lane |
| drop_cnt | output | DW | Saturating count of dropped cells |
| inj_cnt | output | Y*RW | Saturating injection count per panel |

## Verification
The assertions assume that the occupancy flags and requests are stable for the whole cycle and are sampled at the clock edge. They also assume that a flag cleared for the current cycle truly means a free multiplexer input, so a cell placed there is legal. The stimulus changes every input only at the falling edge and draws the flags with a bias toward busy, so that drops happen often. Directed cycles force the cases of all candidates free, only the top candidate free, all candidates busy, and free flags with no request.

// File: rtl/pd_pkg.sv
package pd_pkg;
  // number of stages in one full fabric copy: smallest s with b**s >= n
  function automatic int copy_depth(int ports, int radix);
    int s;
    int v;
    s = 0;
    v = 1;
    while (v < ports) begin
      v = v * radix;
      s = s + 1;
    end
    return (s < 1) ? 1 : s;
  endfunction

  // cyclic successor of a panel index
  function automatic int next_panel(int p, int panels);
    return (p + 1 >= panels) ? 0 : p + 1;
  endfunction

  // cyclic predecessor of a panel index
  function automatic int prev_panel(int p, int panels);
    return (p == 0) ? panels - 1 : p - 1;
  endfunction
endpackage

// File: rtl/pd_slot_demux.sv
module pd_slot_demux #(
  parameter int Y  = 4,
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int PW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     cell_vld,
  input  logic [N*W-1:0]   cell_data,
  output logic [PW-1:0]    slot_o,
  output logic [Y*N-1:0]   out_vld,
  output logic [Y*N*W-1:0] out_data
);
  logic [PW-1:0] slot_q;
  logic [Y-1:0]  panel_any;

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= PW'(pd_pkg::next_panel(int'(slot_q), Y));
  end

  assign slot_o = slot_q;

  for (genvar p = 0; p < Y; p++) begin : g_pnl
    logic hit;
    assign hit = (int'(slot_q) == p);
    assign out_vld[p*N +: N]      = hit ? cell_vld  : '0;
    assign out_data[p*N*W +: N*W] = hit ? cell_data : '0;
    assign panel_any[p]           = |out_vld[p*N +: N];
  end

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_q) < Y);
  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) && (int'($past(slot_q)) != Y-1) |-> (slot_q == $past(slot_q) + PW'(1)));
  // R3
  one_panel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(panel_any));
endmodule

// File: rtl/pd_lane_inject.sv
module pd_lane_inject #(
  parameter int NC    = 3,
  parameter int SW    = 3,
  parameter int FIRST = 4,
  parameter int W     = 8,
  localparam int IW   = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rc_vld,
  input  logic [W-1:0]  rc_data,
  input  logic [NC-1:0] busy,
  output logic          inj_vld,
  output logic [SW-1:0] inj_stage,
  output logic [W-1:0]  inj_data,
  output logic          drop_ev
);
  logic          found;
  logic [IW-1:0] off;

  always_comb begin
    found = 1'b0;
    off   = '0;
    for (int k = NC - 1; k >= 0; k--) begin
      if (!busy[k]) begin
        found = 1'b1;
        off   = IW'(k);
      end
    end
  end

  assign inj_vld   = rc_vld & found;
  assign drop_ev   = rc_vld & ~found;
  assign inj_stage = inj_vld ? (SW'(FIRST) + SW'(off)) : '0;
  assign inj_data  = inj_vld ? rc_data : '0;

  // the point actually used, restated from the reported stage
  logic [SW-1:0] used_off;
  assign used_off = inj_stage - SW'(FIRST);

  // R6
  no_busy_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_vld |-> !busy[used_off]);
  // R7
  drop_all_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |-> (&busy && !inj_vld));
  // R7
  idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_vld |-> (!inj_vld && !drop_ev));
endmodule

// File: rtl/pd_sat_acc.sv
module pd_sat_acc #(
  parameter int K  = 8,
  parameter int CW = 8,
  localparam int KW = $clog2(K + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [K-1:0]  inc,
  output logic [CW-1:0] cnt
);
  logic [KW-1:0] hits;
  logic [CW:0]   sum;

  always_comb begin
    hits = '0;
    for (int i = 0; i < K; i++) hits = hits + KW'(inc[i]);
  end

  assign sum = {1'b0, cnt} + (CW+1)'(hits);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (sum[CW]) cnt <= '1;
    else             cnt <= sum[CW-1:0];
  end

  // R8 R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt >= $past(cnt));
  // R8 R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(inc) == '0 |-> $stable(cnt));
endmodule

// File: rtl/pnl_dispatch.sv
module pnl_dispatch #(
  parameter int Y  = 4,
  parameter int N  = 8,
  parameter int B  = 2,
  parameter int X  = 6,
  parameter int W  = 8,
  parameter int DW = 6,
  parameter int RW = 8,
  localparam int NC    = pd_pkg::copy_depth(N, B),
  localparam int FIRST = X - NC + 1,
  localparam int SW    = $clog2(X + 1),
  localparam int PW    = (Y > 1) ? $clog2(Y) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       cell_vld,
  input  logic [N*W-1:0]     cell_data,
  output logic [PW-1:0]      panel_sel,
  output logic [Y*N-1:0]     pnl_vld,
  output logic [Y*N*W-1:0]   pnl_data,
  input  logic [Y*N-1:0]     rc_vld,
  input  logic [Y*N*W-1:0]   rc_data,
  input  logic [Y*N*NC-1:0]  slot_busy,
  output logic [Y*N-1:0]     inj_vld,
  output logic [Y*N*SW-1:0]  inj_stage,
  output logic [Y*N*W-1:0]   inj_data,
  output logic [DW-1:0]      drop_cnt,
  output logic [Y*RW-1:0]    inj_cnt
);
  logic [Y*N-1:0] drop_ev;

  pd_slot_demux #(.Y(Y), .N(N), .W(W), .PW(PW)) u_demux (
    .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_data(cell_data),
    .slot_o(panel_sel), .out_vld(pnl_vld), .out_data(pnl_data)
  );

  for (genvar j = 0; j < Y; j++) begin : g_dst
    localparam int SRC = pd_pkg::prev_panel(j, Y);
    for (genvar q = 0; q < N; q++) begin : g_lane
      localparam int L  = j*N + q;
      localparam int SL = SRC*N + q;
      pd_lane_inject #(.NC(NC), .SW(SW), .FIRST(FIRST), .W(W)) u_lane (
        .clk(clk), .rst_n(rst_n),
        .rc_vld(rc_vld[SL]), .rc_data(rc_data[SL*W +: W]),
        .busy(slot_busy[L*NC +: NC]),
        .inj_vld(inj_vld[L]), .inj_stage(inj_stage[L*SW +: SW]),
        .inj_data(inj_data[L*W +: W]), .drop_ev(drop_ev[L])
      );
    end
    pd_sat_acc #(.K(N), .CW(RW)) u_inj_acc (
      .clk(clk), .rst_n(rst_n), .inc(inj_vld[j*N +: N]), .cnt(inj_cnt[j*RW +: RW])
    );
  end

  pd_sat_acc #(.K(Y*N), .CW(DW)) u_drop_acc (
    .clk(clk), .rst_n(rst_n), .inc(drop_ev), .cnt(drop_cnt)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (panel_sel == '0 && drop_cnt == '0 && inj_cnt == '0));
  // R4
  serve_or_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inj_vld) + $countones(drop_ev) == $countones(rc_vld));
endmodule

// File: tb/sim_pnl_dispatch.sv
module sim_pnl_dispatch;
  localparam int Y = 4, N = 8, B = 2, X = 6, W = 8, DW = 6, RW = 8;
  localparam int NC = 3, FIRST = 4, SW = 3, PW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] cell_vld = '0;
  logic [N*W-1:0] cell_data = '0;
  logic [PW-1:0] panel_sel;
  logic [Y*N-1:0] pnl_vld;
  logic [Y*N*W-1:0] pnl_data;
  logic [Y*N-1:0] rc_vld = '0;
  logic [Y*N*W-1:0] rc_data = '0;
  logic [Y*N*NC-1:0] slot_busy = '0;
  logic [Y*N-1:0] inj_vld;
  logic [Y*N*SW-1:0] inj_stage;
  logic [Y*N*W-1:0] inj_data;
  logic [DW-1:0] drop_cnt;
  logic [Y*RW-1:0] inj_cnt;

  int total = 0, bad = 0;
  bit done = 0;
  int exp_slot = 0;
  int exp_drop = 0;
  int exp_inj [Y];

  always #10 clk = ~clk;

  pnl_dispatch #(.Y(Y), .N(N), .B(B), .X(X), .W(W), .DW(DW), .RW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_data(cell_data),
    .panel_sel(panel_sel), .pnl_vld(pnl_vld), .pnl_data(pnl_data),
    .rc_vld(rc_vld), .rc_data(rc_data), .slot_busy(slot_busy),
    .inj_vld(inj_vld), .inj_stage(inj_stage), .inj_data(inj_data),
    .drop_cnt(drop_cnt), .inj_cnt(inj_cnt));

  function automatic int lowest_free(logic [NC-1:0] f);
    for (int k = 0; k < NC; k++) if (!f[k]) return k;
    return -1;
  endfunction

  function automatic int sat_add(int a, int b, int mx);
    return (a + b > mx) ? mx : a + b;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // check combinational outputs for current inputs and update the counter model
  task automatic check_comb();
    int drops = 0;
    int inj_n [Y];
    chk("R2 panel_sel", panel_sel, exp_slot);
    for (int p = 0; p < Y; p++) begin
      chk("R3 pnl_vld", pnl_vld[p*N +: N], (p == exp_slot) ? cell_vld : 0);
      chk("R3 pnl_data", pnl_data[p*N*W +: N*W], (p == exp_slot) ? cell_data : 0);
    end
    for (int j = 0; j < Y; j++) begin
      int src = (j == 0) ? Y-1 : j-1;
      inj_n[j] = 0;
      for (int q = 0; q < N; q++) begin
        int l = j*N + q;
        int sl = src*N + q;
        int k = lowest_free(slot_busy[l*NC +: NC]);
        bit ev = rc_vld[sl] && (k >= 0);
        chk("R7 inj_vld", inj_vld[l], ev);
        chk("R4 inj_data", inj_data[l*W +: W], ev ? rc_data[sl*W +: W] : 0);
        if (ev) begin
          chk("R5 inj_stage", inj_stage[l*SW +: SW], FIRST + k);
          chk("R6 free point", slot_busy[l*NC + (int'(inj_stage[l*SW +: SW]) - FIRST)], 0);
          inj_n[j]++;
        end
        if (rc_vld[sl] && k < 0) drops++;
      end
    end
    exp_drop = sat_add(exp_drop, drops, (1 << DW) - 1);
    for (int j = 0; j < Y; j++) exp_inj[j] = sat_add(exp_inj[j], inj_n[j], (1 << RW) - 1);
  endtask

  task automatic check_cnt();
    chk("R8 drop_cnt", drop_cnt, exp_drop);
    for (int j = 0; j < Y; j++) chk("R9 inj_cnt", inj_cnt[j*RW +: RW], exp_inj[j]);
  endtask

  // one cycle: inputs set at falling edge beforehand
  task automatic run_cycle();
    #5;
    check_comb();
    @(posedge clk);
    exp_slot = (exp_slot == Y-1) ? 0 : exp_slot + 1;
    #1;
    check_cnt();
    @(negedge clk);
  endtask

  task automatic rand_inputs(int busy_pct);
    cell_vld = N'($urandom);
    for (int i = 0; i < N; i++) cell_data[i*W +: W] = W'($urandom);
    rc_vld = (Y*N)'($urandom);
    for (int i = 0; i < Y*N; i++) rc_data[i*W +: W] = W'($urandom);
    for (int i = 0; i < Y*N*NC; i++) slot_busy[i] = (($urandom % 100) < busy_pct);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int j = 0; j < Y; j++) exp_inj[j] = 0;
    cell_vld = '1; rc_vld = '1; slot_busy = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, even with activity on the inputs
    chk("R1 panel_sel", panel_sel, 0);
    chk("R1 drop_cnt", drop_cnt, 0);
    chk("R1 inj_cnt", inj_cnt, 0);
    @(negedge clk);
    rst_n = 1;
    cell_vld = '0; rc_vld = '0;

    // R5 all candidates free: lowest stage used
    rc_vld = '1; slot_busy = '0;
    run_cycle();
    // R5 only the top candidate free on every lane
    for (int i = 0; i < Y*N; i++) slot_busy[i*NC +: NC] = 3'b011;
    run_cycle();
    // R5 middle free only
    for (int i = 0; i < Y*N; i++) slot_busy[i*NC +: NC] = 3'b101;
    run_cycle();
    // R7 no request, free flags: nothing injected
    rc_vld = '0; slot_busy = '0;
    run_cycle();
    // R7 R8 all busy: drops, repeated to reach saturation
    rc_vld = '1; slot_busy = '1;
    repeat (3) run_cycle();
    chk("R8 saturated", drop_cnt, (1 << DW) - 1);
    // R4 single request from the last panel wraps to panel 0
    rc_vld = '0; slot_busy = '1;
    rc_vld[(Y-1)*N + 2] = 1'b1;
    rc_data[((Y-1)*N + 2)*W +: W] = 8'hA5;
    slot_busy[(0*N + 2)*NC +: NC] = 3'b110;
    run_cycle();

    // random mix; R2 slot wraps across many cycles, R9 saturates
    for (int c = 0; c < 400; c++) begin
      rand_inputs((c % 3 == 0) ? 90 : 40);
      run_cycle();
    end
    for (int j = 0; j < Y; j++) chk("R9 saturated", inj_cnt[j*RW +: RW], (1 << RW) - 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule